// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Controller

This block holds the digital register state behind a four-channel digital-to-analog converter. A serial receiver that sits outside this block presents each complete 24-bit frame as a 3-bit command, a 3-bit address and a data word, together with a one-cycle valid strobe. Each channel has two registers. The staging register is written by frames. The output register drives the converter code. Software controls when the staged value moves to the output. It can move one channel, move all channels at once, or set a channel to follow its staging register after every accepted frame.

The block also keeps a 2-bit power-down mode for each channel and a 4-bit auto-follow mask. A software reset comes in two levels: one clears only the data registers, and the other also clears the control state. Power-down settings never change the stored output codes. When a channel returns to normal operation, it resumes at the code it held before power-down. A parameter selects the code width. A narrower code is taken from the most significant bits of the data field.

Top module: `quad_dbuf_ctrl`

## Requirements
- R1: After a synchronous reset, every output code is 0, every power-down mode is 0 (normal), and the auto-follow mask is 0.
- R2: Command 000 writes the staging register of the addressed channel(s). The output code is not changed unless that channel follows automatically.
- R3: Command 001 copies the staging register of the addressed channel(s) into the output register.
- R4: Command 010 writes the staging register of the addressed channel(s). In the same cycle, all four output registers take their staging values, including the value just written.
- R5: Command 011 writes the staging register of the addressed channel(s) and updates the output of those channels with the new value.
- R6: Address 0, 1, 2 and 3 select channel 0, 1, 2 and 3, and address 7 selects all four channels. For commands 000 to 011, addresses 4, 5 and 6 make the frame have no effect at all.
- R7: Command 110 loads the auto-follow mask from data bits 3..0, where bit i belongs to channel i. On every accepted frame other than a software reset, each channel whose mask bit was set before that frame copies its staging value, after any write in the frame, into its output register.
- R8: Command 100 sets the mode of every channel i whose data bit i is 1 to the value in data bits 5:4. The mode codes are 0 = normal, 1 = 1 kΩ to ground, 2 = 100 kΩ to ground and 3 = high impedance. The modes of other channels and all stored codes are left unchanged.
- R9: Command 101 with data bit 0 = 0 clears all staging and output registers and keeps the mask and the modes.
- R10: Command 101 with data bit 0 = 1 clears all staging and output registers, the auto-follow mask and all modes, giving the same state as R1.
- R11: Command 111 is reserved and has no effect.
- R12: The stored code is the top CODE_W bits of the DATA_W-bit data field. Any lower data bits are ignored for codes.
- R13: A frame strobed at a clock edge changes all affected outputs at that same edge, together.
- R14: While frm_valid is low, no output or internal state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe that marks a decoded frame |
| frm_cmd | input | 3 | Frame command |
| frm_addr | input | 3 | Frame channel address |
| frm_data | input | DATA_W | Frame data word |
| code_out | output | 4*CODE_W | Output codes; channel i occupies bits [i*CODE_W +: CODE_W] |
| pd_mode_out | output | 8 | Power-down modes; channel i occupies bits [2*i +: 2] |

## Verification
The bench targets the combinations where ordering matters.

- **Write and update in one frame.** A design that copied the old staging value would lag one frame behind on commands 010 and 011.
- **Auto-follow mask loaded while enabled.** If the new mask were applied within the same frame, a channel would update one frame early.
- **Partial reset.** A partial reset that also cleared the mask or the modes would give wrong modes after it.
- **Reserved command and addresses 4 to 6.** A design that treated these as broadcast or channel 0 would corrupt codes that should stay unchanged.
- **Narrow code variant.** A second instance with 12-bit codes shows whether the code is taken from the wrong end of the data field.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

    localparam int NCH      = 4;
    localparam int PD_W     = 2;
    localparam int CMD_W    = 3;
    localparam int ADDR_W   = 3;
    localparam int PD_LSB   = 4;
    localparam logic [ADDR_W-1:0] ADDR_ALL = 3'b111;

    typedef enum logic [CMD_W-1:0] {
        CMD_WR_IN      = 3'd0,
        CMD_UPD        = 3'd1,
        CMD_WR_UPD_ALL = 3'd2,
        CMD_WR_UPD     = 3'd3,
        CMD_PWR        = 3'd4,
        CMD_SRST       = 3'd5,
        CMD_AU_LOAD    = 3'd6,
        CMD_RSVD       = 3'd7
    } cmd_e;

    typedef enum logic [PD_W-1:0] {
        PD_NORMAL = 2'd0,
        PD_R1K    = 2'd1,
        PD_R100K  = 2'd2,
        PD_HIZ    = 2'd3
    } pd_e;

    typedef struct packed {
        logic [NCH-1:0] wr_in;     // staging write per channel
        logic [NCH-1:0] ld_sel;    // explicit output load per channel
        logic           ld_all;    // broadcast output load
        logic           au_load;   // load auto-follow mask
        logic           pd_load;   // apply power-down mode to masked channels
        logic           clr_data;  // clear staging and output registers
        logic           clr_ctrl;  // clear mask and modes
        logic           accept;    // frame takes effect (enables auto-follow)
    } ctl_t;

    function automatic logic [NCH-1:0] chan_sel(input logic [ADDR_W-1:0] a);
        logic [NCH-1:0] s;
        s = '0;
        if (a == ADDR_ALL)
            s = '1;
        else if (a < ADDR_W'(NCH))
            s[a[1:0]] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/qdb_decode.sv
module qdb_decode
    import qdb_pkg::*;
(
    input  logic              valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              srst_full,
    output ctl_t              ctl
);

    logic [NCH-1:0] sel;
    logic           sel_ok;

    always_comb begin
        sel    = chan_sel(addr);
        sel_ok = |sel;
        ctl    = '0;
        if (valid) begin
            case (cmd_e'(cmd))
                CMD_WR_IN: if (sel_ok) begin
                    ctl.wr_in  = sel;
                    ctl.accept = 1'b1;
                end
                CMD_UPD: if (sel_ok) begin
                    ctl.ld_sel = sel;
                    ctl.accept = 1'b1;
                end
                CMD_WR_UPD_ALL: if (sel_ok) begin
                    ctl.wr_in  = sel;
                    ctl.ld_all = 1'b1;
                    ctl.accept = 1'b1;
                end
                CMD_WR_UPD: if (sel_ok) begin
                    ctl.wr_in  = sel;
                    ctl.ld_sel = sel;
                    ctl.accept = 1'b1;
                end
                CMD_PWR: begin
                    ctl.pd_load = 1'b1;
                    ctl.accept  = 1'b1;
                end
                CMD_SRST: begin
                    ctl.clr_data = 1'b1;
                    ctl.clr_ctrl = srst_full;
                end
                CMD_AU_LOAD: begin
                    ctl.au_load = 1'b1;
                    ctl.accept  = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/qdb_ctrl_regs.sv
module qdb_ctrl_regs
    import qdb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  ctl_t                     ctl,
    input  logic [PD_LSB+PD_W-1:0]   fld,
    output logic [NCH-1:0]           au_q,
    output logic [NCH-1:0][PD_W-1:0] pd_q
);

    always_ff @(posedge clk) begin
        if (rst || ctl.clr_ctrl) begin
            au_q <= '0;
            pd_q <= '0;
        end else begin
            if (ctl.au_load)
                au_q <= fld[NCH-1:0];
            if (ctl.pd_load) begin
                for (int i = 0; i < NCH; i++)
                    if (fld[i])
                        pd_q[i] <= fld[PD_LSB +: PD_W];
            end
        end
    end

endmodule

// File: rtl/qdb_chan.sv
module qdb_chan #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr,
    input  logic              ld,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] out_q;
    logic [CODE_W-1:0] stage_nx;

    always_comb stage_nx = wr ? din : stage_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stage_q <= '0;
            out_q   <= '0;
        end else begin
            stage_q <= stage_nx;
            if (ld)
                out_q <= stage_nx;
        end
    end

    assign code = out_q;

endmodule

// File: rtl/quad_dbuf_ctrl.sv
module quad_dbuf_ctrl
    import qdb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CODE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frm_valid,
    input  logic [CMD_W-1:0]      frm_cmd,
    input  logic [ADDR_W-1:0]     frm_addr,
    input  logic [DATA_W-1:0]     frm_data,
    output logic [NCH*CODE_W-1:0] code_out,
    output logic [NCH*PD_W-1:0]   pd_mode_out
);

    localparam int CODE_LSB = DATA_W - CODE_W;

    ctl_t                     ctl;
    logic [NCH-1:0]           au_q;
    logic [NCH-1:0][PD_W-1:0] pd_q;
    logic [CODE_W-1:0]        din;

    assign din = frm_data[CODE_LSB +: CODE_W];

    qdb_decode u_decode (
        .valid     (frm_valid),
        .cmd       (frm_cmd),
        .addr      (frm_addr),
        .srst_full (frm_data[0]),
        .ctl       (ctl)
    );

    qdb_ctrl_regs u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .fld  (frm_data[PD_LSB+PD_W-1:0]),
        .au_q (au_q),
        .pd_q (pd_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic ld;
        assign ld = ctl.ld_sel[g] | ctl.ld_all | (ctl.accept & au_q[g]);

        qdb_chan #(.CODE_W(CODE_W)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .clr  (ctl.clr_data),
            .wr   (ctl.wr_in[g]),
            .ld   (ld),
            .din  (din),
            .code (code_out[g*CODE_W +: CODE_W])
        );

        assign pd_mode_out[g*PD_W +: PD_W] = pd_q[g];
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> $stable(code_out) && $stable(pd_mode_out)); // R14

    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_cmd == CMD_RSVD |=> $stable(code_out) && $stable(pd_mode_out)); // R11

    AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_cmd <= CMD_WR_UPD && frm_addr >= 3'd4 && frm_addr <= 3'd6
        |=> $stable(code_out) && $stable(pd_mode_out)); // R6

    AST_PWR_KEEPS_CODES: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_cmd == CMD_PWR && au_q == '0 |=> $stable(code_out)); // R8

    AST_FULL_RESET: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_cmd == CMD_SRST && frm_data[0]
        |=> code_out == '0 && pd_mode_out == '0 && au_q == '0); // R10

    AST_PART_RESET: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_cmd == CMD_SRST && !frm_data[0]
        |=> code_out == '0 && $stable(pd_mode_out) && $stable(au_q)); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_cmd == CMD_AU_LOAD |=> au_q == $past(frm_data[NCH-1:0])); // R7

endmodule

// File: tb/test_quad_dbuf_ctrl.sv
module test_quad_dbuf_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NRAND      = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [2:0]  frm_cmd = '0;
    logic [2:0]  frm_addr = '0;
    logic [15:0] frm_data = '0;
    logic [63:0] code16;
    logic [47:0] code12;
    logic [7:0]  pd16;
    logic [7:0]  pd12;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_dbuf_ctrl #(.DATA_W(16), .CODE_W(16)) i_quad_dbuf_ctrl (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
        .frm_addr(frm_addr), .frm_data(frm_data),
        .code_out(code16), .pd_mode_out(pd16));

    quad_dbuf_ctrl #(.DATA_W(16), .CODE_W(12)) i_quad_dbuf_ctrl_n12 (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
        .frm_addr(frm_addr), .frm_data(frm_data),
        .code_out(code12), .pd_mode_out(pd12));

    // behavioural reference model
    logic [15:0] m_in  [4];
    logic [15:0] m_out [4];
    logic [1:0]  m_pd  [4];
    logic [3:0]  m_au;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string phase = "R1";

    task automatic model_frame(input logic [2:0] c, input logic [2:0] a, input logic [15:0] d);
        logic [3:0] sel;
        logic [3:0] old_au;
        old_au = m_au;
        sel = (a == 3'd7) ? 4'hF : (a < 3'd4) ? (4'b1 << a) : 4'h0;
        case (c)
            3'd0: begin
                if (sel == 0) return;
                for (int i = 0; i < 4; i++) if (sel[i]) m_in[i] = d;
            end
            3'd1: begin
                if (sel == 0) return;
                for (int i = 0; i < 4; i++) if (sel[i]) m_out[i] = m_in[i];
            end
            3'd2: begin
                if (sel == 0) return;
                for (int i = 0; i < 4; i++) if (sel[i]) m_in[i] = d;
                for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
            end
            3'd3: begin
                if (sel == 0) return;
                for (int i = 0; i < 4; i++) if (sel[i]) begin m_in[i] = d; m_out[i] = d; end
            end
            3'd4: for (int i = 0; i < 4; i++) if (d[i]) m_pd[i] = d[5:4];
            3'd5: begin
                for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
                if (d[0]) begin
                    m_au = 0;
                    for (int i = 0; i < 4; i++) m_pd[i] = 0;
                end
                return;
            end
            3'd6: m_au = d[3:0];
            default: return;
        endcase
        for (int i = 0; i < 4; i++) if (old_au[i]) m_out[i] = m_in[i];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_au = 0;
            for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; m_pd[i] = 0; end
        end else if (frm_valid) begin
            model_frame(frm_cmd, frm_addr, frm_data);
        end
    end

    // compare on every clock, away from the active edge; R13: same-edge update of all outputs
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < 4; i++) begin
                n_vec++;
                if (code16[i*16 +: 16] !== m_out[i]) begin
                    n_bad++;
                    $display("FAIL %s/R13 ch%0d code16 actual=%h expected=%h", phase, i, code16[i*16 +: 16], m_out[i]);
                end
                n_vec++;
                if (code12[i*12 +: 12] !== m_out[i][15:4]) begin
                    n_bad++;
                    $display("FAIL %s/R12 ch%0d code12 actual=%h expected=%h", phase, i, code12[i*12 +: 12], m_out[i][15:4]);
                end
                n_vec++;
                if (pd16[i*2 +: 2] !== m_pd[i] || pd12[i*2 +: 2] !== m_pd[i]) begin
                    n_bad++;
                    $display("FAIL %s/R8 ch%0d mode actual=%0d/%0d expected=%0d", phase, i, pd16[i*2 +: 2], pd12[i*2 +: 2], m_pd[i]);
                end
            end
        end
    end

    task automatic send(input logic [2:0] c, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        frm_valid = 1'b1; frm_cmd = c; frm_addr = a; frm_data = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            frm_valid = 1'b0;
            frm_data  = $urandom();
        end
    endtask

    task automatic direct_check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        phase = "R1";
        direct_check("R1 reset codes", code16, 64'h0);
        direct_check("R1 reset modes", {56'h0, pd16}, 64'h0);

        phase = "R2";  // staging write leaves output alone
        send(3'd0, 3'd1, 16'h1234); idle(2);
        direct_check("R2 output unchanged", code16, 64'h0);
        phase = "R3";
        send(3'd1, 3'd1, 16'hFFFF); idle(2);
        direct_check("R3 copy ch1", code16, 64'h0000_0000_1234_0000);
        phase = "R5";
        send(3'd3, 3'd3, 16'hABCD); idle(2);
        phase = "R12";
        direct_check("R12 narrow code ch3", {52'h0, code12[47:36]}, 64'hABC);
        phase = "R4";
        send(3'd0, 3'd0, 16'h0AAA);
        send(3'd2, 3'd2, 16'h5555); idle(2);
        phase = "R6";
        for (int a = 4; a < 7; a++) for (int c = 0; c < 4; c++) send(3'(c), 3'(a), 16'hDEAD);
        send(3'd3, 3'd7, 16'h7777); idle(1);
        phase = "R11";
        send(3'd7, 3'd7, 16'hFFFF); idle(2);
        phase = "R8";
        send(3'd4, 3'd0, 16'h0035);   // mode 3 on ch0, ch2
        send(3'd4, 3'd0, 16'h0012);   // mode 1 on ch1
        send(3'd4, 3'd0, 16'h0020);   // empty mask
        idle(2);
        phase = "R7";
        send(3'd6, 3'd0, 16'h0005);   // ch0, ch2 follow
        send(3'd6, 3'd0, 16'h0003);   // reload while enabled
        send(3'd0, 3'd0, 16'h1111);
        send(3'd0, 3'd2, 16'h2222);
        send(3'd0, 3'd1, 16'h3333);
        send(3'd4, 3'd0, 16'h0001);
        idle(2);
        phase = "R9";
        send(3'd5, 3'd0, 16'hFFFE); idle(1);
        send(3'd0, 3'd0, 16'h4444); idle(2);
        phase = "R10";
        send(3'd5, 3'd0, 16'h0001); idle(2);
        direct_check("R10 codes", code16, 64'h0);
        direct_check("R10 modes", {56'h0, pd16}, 64'h0);

        phase = "R14";
        for (int n = 0; n < NRAND; n++) begin
            int r;
            logic [2:0] a;
            r = $urandom_range(0, 9);
            a = (r < 6) ? 3'(r % 4) : (r < 8) ? 3'd7 : 3'($urandom_range(4, 6));
            if ($urandom_range(0, 4) == 0) idle(1);
            send(3'($urandom_range(0, 7)), a, 16'($urandom()));
        end
        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule